// File: doc/BRIEF.md
# UTOPIA Receive Cell Port

This block is the physical-layer side of the receive half of a UTOPIA-style cell interface. It takes ATM cell bytes from an internal receive byte buffer and hands them to an ATM-layer reader. The buffer is a show-ahead byte queue: it reports its fill level and exposes its two oldest bytes. The block drives a cell-available flag, a start-of-cell marker and a data bus that is 8 or 16 bits wide. It samples the reader's active-low read enable.

The block holds one word in an output register ahead of time. A word moves to the reader on every rising clock edge at which the enable is low while cell-available is high. A small configuration register sets the bus width, the cell length (52 or 54 bytes) and the handshake style. In cell-level handshaking the flag promises a whole cell. In octet-level handshaking it only promises the next word. A multi-PHY setting forces cell-level handshaking whatever the handshake bit holds.

Top module: `utopia_rx_port`

## Requirements
- R1: While reset is applied and just after it, the configuration reads 0 (8-bit bus, 54-byte cells, cell-level handshaking), and cell-available and start-of-cell are low.
- R2: A configuration write stores bit 0 (16-bit bus), bit 3 (52-byte cells), bit 4 (multi-PHY) and bit 5 (octet-level handshaking when 1). Readback returns those four bits, and all other bits read 0.
- R3: Bytes reach the reader in buffer order. On a 16-bit bus the earlier byte is on bits 15:8 and the later byte is on bits 7:0. On an 8-bit bus the byte is on bits 7:0 and bits 15:8 read 0.
- R4: A cell is 54 or 52 transfers on an 8-bit bus, and 27 or 26 words on a 16-bit bus. Start-of-cell is high with word 0 of each cell and only with word 0.
- R5: In cell-level mode, at a cell boundary, cell-available is high only when a complete cell is held (the presented word plus the buffer level).
- R6: In cell-level mode, cell-available stays high through a cell once it has begun. It falls in the cycle after the last word when no further complete cell is held.
- R7: In octet-level mode, cell-available is high exactly when a word is ready for the next edge, and it may fall in the middle of a cell.
- R8: With multi-PHY set, the octet-level bit is ignored and cell-level handshaking applies.
- R9: While the enable is high and cell-available is high, the data bus and start-of-cell hold their values and the word position does not advance.
- R10: Each loaded word pops one byte from the buffer on an 8-bit bus and two bytes on a 16-bit bus, and the block never pops more than the buffer level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration readback |
| buf_level | input | LVL_W | Bytes held in the receive buffer |
| buf_data | input | 16 | Oldest buffer byte on 7:0, next byte on 15:8 |
| buf_pop | output | 1 | Pop bytes from the buffer at this edge |
| buf_pop_two | output | 1 | With buf_pop, pop two bytes instead of one |
| rx_clav | output | 1 | Cell-available flag to the reader |
| rx_enb_n | input | 1 | Active-low read enable from the reader |
| rx_soc | output | 1 | Start-of-cell marker |
| rx_data | output | 16 | Receive data bus |

## Verification
The hardest case to reach is a cell-available flag that depends on how many bytes lie beyond the current cell. Examples are a trailing partial cell, a cell boundary crossed with a half-filled buffer in octet-level mode, and a partial cell with multi-PHY and the octet-level bit both set. The vector table loads the buffer with whole cells plus a chosen remainder of bytes. It then drains the buffer with different enable duty patterns and checks the flag on every cycle against a count of consumed bytes. Directed tests hold the enable high on word 0 to show that the bus and the marker are held.

// File: rtl/utopia_rx_pkg.sv
package utopia_rx_pkg;

  localparam int CFG_W      = 8;
  localparam int BIT_BUS16  = 0;
  localparam int BIT_CELL52 = 3;
  localparam int BIT_MPHY   = 4;
  localparam int BIT_OCTET  = 5;
  localparam logic [CFG_W-1:0] CFG_MASK =
    CFG_W'((1 << BIT_BUS16) | (1 << BIT_CELL52) | (1 << BIT_MPHY) | (1 << BIT_OCTET));

  localparam int CELL_LONG  = 54;
  localparam int CELL_SHORT = 52;
  localparam int LEN_W      = 7;
  localparam int POS_W      = 6;
  localparam int DATA_W     = 16;
  localparam int BYTE_W     = DATA_W / 2;

  typedef struct packed {
    logic octet_hs;
    logic multi_phy;
    logic cell52;
    logic bus16;
  } rx_cfg_t;

  function automatic logic [LEN_W-1:0] cell_len(input logic cell52);
    return cell52 ? LEN_W'(CELL_SHORT) : LEN_W'(CELL_LONG);
  endfunction

  function automatic logic [POS_W-1:0] last_idx(input logic cell52, input logic bus16);
    logic [LEN_W-1:0] n;
    n = cell_len(cell52);
    if (bus16) n = n >> 1;
    return POS_W'(n - LEN_W'(1));
  endfunction

endpackage

// File: rtl/utopia_rx_cfg.sv
module utopia_rx_cfg
  import utopia_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] rd_data,
  output rx_cfg_t          cfg
);

  rx_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.bus16     = wr_data[BIT_BUS16];
      cfg_d.cell52    = wr_data[BIT_CELL52];
      cfg_d.multi_phy = wr_data[BIT_MPHY];
      cfg_d.octet_hs  = wr_data[BIT_OCTET];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    rd_data             = '0;
    rd_data[BIT_BUS16]  = cfg_q.bus16;
    rd_data[BIT_CELL52] = cfg_q.cell52;
    rd_data[BIT_MPHY]   = cfg_q.multi_phy;
    rd_data[BIT_OCTET]  = cfg_q.octet_hs;
  end

  assign cfg = cfg_q;

  // R2: a write is visible on the readback port in the next cycle
  p_cfg_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & CFG_MASK));

endmodule

// File: rtl/utopia_rx_seq.sv
module utopia_rx_seq
  import utopia_rx_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus16,
  input  logic             cell52,
  input  logic             xfer,
  input  logic [LVL_W-1:0] buf_level,
  output logic             load,
  output logic             out_valid,
  output logic [POS_W-1:0] pos,
  output logic             last_word
);

  logic             valid_q, valid_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             can_load;

  assign last_word = (pos_q >= last_idx(cell52, bus16));
  assign can_load  = bus16 ? (buf_level >= LVL_W'(2)) : (buf_level != '0);
  assign load      = can_load && (!valid_q || xfer);

  always_comb begin
    valid_d = valid_q;
    pos_d   = pos_q;
    if (xfer) begin
      valid_d = 1'b0;
      pos_d   = last_word ? '0 : pos_q + POS_W'(1);
    end
    if (load) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pos_q   <= '0;
    end else begin
      valid_q <= valid_d;
      pos_q   <= pos_d;
    end
  end

  assign out_valid = valid_q;
  assign pos       = pos_q;

endmodule

// File: rtl/utopia_rx_clav.sv
module utopia_rx_clav
  import utopia_rx_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  rx_cfg_t          cfg,
  input  logic             out_valid,
  input  logic [POS_W-1:0] pos,
  input  logic [LVL_W-1:0] buf_level,
  output logic             clav,
  output logic             octet_eff
);

  localparam int EXT_W = LVL_W + 1;

  logic [EXT_W-1:0] word_bytes;
  logic [EXT_W-1:0] need_bytes;
  logic [EXT_W-1:0] level_ext;
  logic             cell_ok;

  assign octet_eff  = cfg.octet_hs & ~cfg.multi_phy;
  assign word_bytes = cfg.bus16 ? EXT_W'(2) : EXT_W'(1);
  assign need_bytes = EXT_W'(cell_len(cfg.cell52)) - word_bytes;
  assign level_ext  = {1'b0, buf_level};

  assign cell_ok = out_valid && ((pos != '0) || (level_ext >= need_bytes));
  assign clav    = octet_eff ? out_valid : cell_ok;

endmodule

// File: rtl/utopia_rx_dreg.sv
module utopia_rx_dreg
  import utopia_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              bus16,
  input  logic [DATA_W-1:0] buf_data,
  output logic [DATA_W-1:0] data
);

  logic [DATA_W-1:0] data_q, data_d;
  logic [DATA_W-1:0] fresh;

  assign fresh  = bus16 ? {buf_data[BYTE_W-1:0], buf_data[DATA_W-1:BYTE_W]}
                        : {{BYTE_W{1'b0}}, buf_data[BYTE_W-1:0]};
  assign data_d = load ? fresh : data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign data = data_q;

endmodule

// File: rtl/utopia_rx_port.sv
module utopia_rx_port
  import utopia_rx_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [LVL_W-1:0]  buf_level,
  input  logic [DATA_W-1:0] buf_data,
  output logic              buf_pop,
  output logic              buf_pop_two,
  output logic              rx_clav,
  input  logic              rx_enb_n,
  output logic              rx_soc,
  output logic [DATA_W-1:0] rx_data
);

  // reset: asserted at once, released through two flops
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  rx_cfg_t          cfg;
  logic             load, out_valid, last_word, octet_eff, xfer;
  logic [POS_W-1:0] pos;

  utopia_rx_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .rd_data (cfg_rdata),
    .cfg     (cfg)
  );

  utopia_rx_seq #(.LVL_W(LVL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .bus16     (cfg.bus16),
    .cell52    (cfg.cell52),
    .xfer      (xfer),
    .buf_level (buf_level),
    .load      (load),
    .out_valid (out_valid),
    .pos       (pos),
    .last_word (last_word)
  );

  utopia_rx_clav #(.LVL_W(LVL_W)) u_clav (
    .cfg       (cfg),
    .out_valid (out_valid),
    .pos       (pos),
    .buf_level (buf_level),
    .clav      (rx_clav),
    .octet_eff (octet_eff)
  );

  utopia_rx_dreg u_dreg (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .load     (load),
    .bus16    (cfg.bus16),
    .buf_data (buf_data),
    .data     (rx_data)
  );

  assign xfer        = !rx_enb_n && rx_clav;
  assign rx_soc      = out_valid && (pos == '0);
  assign buf_pop     = load;
  assign buf_pop_two = load && cfg.bus16;

  // R9: an idle reader sees a frozen bus and marker
  p_hold_bus_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (rx_enb_n && rx_clav && !cfg_we) |=> ($stable(rx_data) && $stable(rx_soc)));

  // R6: cell-level mode keeps the flag up inside a started cell
  p_cell_mid_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!octet_eff && xfer && !last_word && !cfg_we) |=> rx_clav);

  // R4: after any word but the last, the next word is not word 0
  p_soc_only_first_r4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (xfer && !last_word) |=> !rx_soc);

  // R10: a pop never asks for more bytes than the buffer holds
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    buf_pop |-> (buf_level >= (buf_pop_two ? LVL_W'(2) : LVL_W'(1))));

endmodule

// File: tb/tb_utopia_rx_port.sv
module tb_utopia_rx_port;

  localparam int CLK_PERIOD = 10;
  localparam int LVL_W      = 8;
  localparam int NVEC       = 8;

  // vector fields: cfg[19:12], bytes pushed[11:4], enable-low pattern[3:0]
  localparam logic [19:0] VECS [0:NVEC-1] = '{
    {8'h00, 8'd108, 4'hF},   // R3 R4 8-bit, 54-byte, two cells
    {8'h01, 8'd108, 4'h5},   // R3 R4 R9 16-bit, 54-byte, alternating enable
    {8'h09, 8'd114, 4'hF},   // R5 R6 16-bit, 52-byte, trailing partial cell
    {8'h08, 8'd82,  4'hB},   // R5 8-bit, 52-byte, partial cell
    {8'h21, 8'd60,  4'hF},   // R7 octet-level, 16-bit, drops mid-cell
    {8'h31, 8'd60,  4'hF},   // R8 multi-PHY overrides octet bit
    {8'h20, 8'd20,  4'h6},   // R7 octet-level, 8-bit
    {8'h19, 8'd104, 4'h3}    // R8 R4 multi-PHY, 52-byte, 16-bit
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [LVL_W-1:0] buf_level;
  logic [15:0] buf_data;
  logic        buf_pop, buf_pop_two;
  logic        rx_clav, rx_soc;
  logic        rx_enb_n = 1'b1;
  logic [15:0] rx_data;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  logic [7:0] mem [0:1023];
  int wr = 0;
  int rd = 0;
  int base = 0;
  logic flush = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign buf_level = ((wr - rd) > 255) ? 8'd255 : 8'(wr - rd);
  assign buf_data  = {mem[(rd + 1) & 1023], mem[rd & 1023]};

  always @(posedge clk) begin
    if (flush)        rd <= wr;
    else if (buf_pop) rd <= rd + (buf_pop_two ? 2 : 1);
  end

  utopia_rx_port #(.LVL_W(LVL_W)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .buf_level   (buf_level),
    .buf_data    (buf_data),
    .buf_pop     (buf_pop),
    .buf_pop_two (buf_pop_two),
    .rx_clav     (rx_clav),
    .rx_enb_n    (rx_enb_n),
    .rx_soc      (rx_soc),
    .rx_data     (rx_data)
  );

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fails = n_fails + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int expv);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_fails = n_fails + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] byte_at(input int k);
    return mem[(base + k) & 1023];
  endfunction

  task automatic push(input int n);
    for (int i = 0; i < n; i++) mem[(wr + i) & 1023] = 8'((wr + i) * 37 + 11);
    wr = wr + n;
  endtask

  task automatic restart();
    @(negedge clk);
    rst_n = 1'b0;
    flush = 1'b1;
    rx_enb_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    flush = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    check(cfg_rdata == (v & 8'h39), "R2 readback", cfg_rdata, v & 8'h39);
  endtask

  task automatic run_vec(input logic [7:0] cfg, input int n, input logic [3:0] pat);
    int wb, cb, k, expect_done;
    logic octet, exp_clav;
    logic [15:0] exp_word;
    restart();
    write_cfg(cfg);
    base = wr;
    push(n);
    repeat (3) @(negedge clk);
    wb = cfg[0] ? 2 : 1;
    cb = cfg[3] ? 52 : 54;
    octet = cfg[5] && !cfg[4];
    k = 0;
    for (int cyc = 0; cyc < 2 * n + 20; cyc++) begin
      rx_enb_n = !pat[cyc % 4];
      if (octet) exp_clav = (n - k) >= wb;
      else       exp_clav = ((k % cb) != 0) || ((n - k) >= cb);
      check(rx_clav == exp_clav,
            octet ? "R7 octet clav" : (cfg[4] ? "R8 forced cell clav" : "R5/R6 cell clav"),
            rx_clav, exp_clav);
      if (!rx_enb_n && rx_clav) begin
        exp_word = (wb == 2) ? {byte_at(k), byte_at(k + 1)} : {8'h00, byte_at(k)};
        check(rx_data == exp_word, "R3 data order", rx_data, exp_word);
        check(rx_soc == ((k % cb) == 0), "R4 soc on word 0", rx_soc, (k % cb) == 0);
        k = k + wb;
      end
      @(negedge clk);
    end
    rx_enb_n = 1'b1;
    expect_done = octet ? (n - (n % wb)) : ((n / cb) * cb);
    check(k == expect_done, "R4 bytes delivered", k, expect_done);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (2) @(negedge clk);
    // R1: state while reset is held
    check(rx_clav == 1'b0, "R1 clav in reset", rx_clav, 0);
    check(rx_soc == 1'b0, "R1 soc in reset", rx_soc, 0);
    check(cfg_rdata == 8'h00, "R1 cfg in reset", cfg_rdata, 0);

    for (int v = 0; v < NVEC; v++)
      run_vec(VECS[v][19:12], int'(VECS[v][11:4]), VECS[v][3:0]);

    // R2: all-ones write keeps only the defined bits; R1: reset clears them
    restart();
    write_cfg(8'hFF);
    restart();
    check(cfg_rdata == 8'h00, "R1 cfg after reset", cfg_rdata, 0);
    check(rx_clav == 1'b0, "R1 clav after reset", rx_clav, 0);

    // R9: hold on word 0 with enable high, then one transfer
    write_cfg(8'h01);
    base = wr;
    push(54);
    repeat (3) @(negedge clk);
    for (int h = 0; h < 5; h++) begin
      check(rx_data == {byte_at(0), byte_at(1)}, "R9 data held", rx_data, {byte_at(0), byte_at(1)});
      check(rx_soc == 1'b1, "R9 soc held", rx_soc, 1);
      @(negedge clk);
    end
    rx_enb_n = 1'b0;
    @(negedge clk);
    rx_enb_n = 1'b1;
    check(rx_data == {byte_at(2), byte_at(3)}, "R9 advance after enable", rx_data, {byte_at(2), byte_at(3)});
    check(rx_soc == 1'b0, "R4 soc low on word 1", rx_soc, 0);
    check(rx_clav == 1'b1, "R6 clav mid-cell", rx_clav, 1);

    // R5 R10: partial cell in cell-level mode, 8-bit bus
    restart();
    write_cfg(8'h00);
    base = wr;
    push(53);
    repeat (3) @(negedge clk);
    check(rx_clav == 1'b0, "R5 partial cell hidden", rx_clav, 0);
    check(rx_data == {8'h00, byte_at(0)}, "R10 single-byte load", rx_data, {8'h00, byte_at(0)});
    push(1);
    repeat (2) @(negedge clk);
    check(rx_clav == 1'b1, "R5 full cell shown", rx_clav, 1);

    summary();
    $finish;
  end

endmodule